// File: doc/BRIEF.md
# DMA Page Table Translation Engine

This block turns a DMA virtual address into a physical address. It does this with one lookup in a flat table of 64-bit entries held in system memory. A requester presents the address together with the current control and table-base register values on a valid/ready request port. The engine then works out which table entry covers the address and fetches it with a single 64-bit read on its memory port. It decodes the returned entry and reports four things: the physical address, the physical page base, the in-page offset mask and a permission code. The result stays on the result port until the requester accepts it.

The control value selects three things:
- Whether translation is on. With translation off, the engine passes the address straight through.
- Whether the table is indexed at 8 KB or 64 KB granularity.
- A 3-bit size code that sets how many address bits form the index.

Each entry marks its own page as 8 KB or 64 KB, whatever the table granularity. At most one memory read is in flight at any time.

The memory port carries each entry as one 64-bit big-endian word. The byte at the lowest address sits in bits 63:56, so the engine reads the entry bits straight from the data bus.

Top module: `dma_xlate_engine`

## Requirements
- R1: When control bit 0 is 0, no memory read is issued. The result is valid one cycle after the request is accepted, with these values:
  - physical address equal to the virtual address;
  - page base equal to the virtual address with bits 12:0 cleared;
  - offset mask 0x1FFF;
  - permission read-write.
- R2: When control bit 0 is 1 and control bit 2 is 0, the entry read address is base + 8 × vaddr[22+n:13], where n is control bits 18:16 (n = 0..7).
- R3: When control bits 0 and 2 are both 1 and n ≤ 5, the entry read address is base + 8 × vaddr[25+n:16].
- R4: When control bits 0 and 2 are both 1 and n is 6 or 7, no memory read is issued. The result is valid one cycle after acceptance with permission none and zero address, base and mask.
- R5: An entry with bit 63 clear gives permission none and zero address, base and mask.
- R6: For a valid entry, bit 1 set gives permission read-write (code 2'b11) and bit 1 clear gives read-only (code 2'b01). Permission none is code 2'b00.
- R7: For a valid entry with bit 61 set:
  - the page base is entry AND 0x1FFFFFF8000 (bits 40:15);
  - the offset mask is 0xFFFF;
  - the physical address is the page base OR vaddr[15:0].
- R8: For a valid entry with bit 61 clear:
  - the page base is entry AND 0x1FFFFFFE000 (bits 40:13);
  - the offset mask is 0x1FFF;
  - the physical address is the page base OR vaddr[12:0].
- R9: A read response that carries the error flag gives permission none and zero address, base and mask, whatever the data.
- R10: The read request appears one cycle after acceptance. It holds its address stable until the memory accepts it. Each lookup issues at most one read, and req_ready stays low while a lookup is in progress.
- R11: The result becomes valid one cycle after the response beat. It stays unchanged until res_ready is seen, and the engine is ready again in the cycle after that.
- R12: After reset, req_ready is 1 and mem_rd_valid and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_vaddr | input | ADDR_W | DMA virtual address |
| req_ctrl | input | CTRL_W | Control value: bit 0 enable, bit 2 64K granularity, bits 18:16 size code |
| req_base | input | ADDR_W | Table base address |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read response beat |
| mem_rsp_data | input | 64 | Entry word, big-endian byte order |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | ADDR_W | Translated physical address |
| res_page_base | output | ADDR_W | Physical page base |
| res_offset_mask | output | ADDR_W | In-page offset mask |
| res_perm | output | 2 | 00 none, 01 read-only, 11 read-write |

## Verification
Each result has a fixed timing:
- A bypass or unsupported-size lookup presents its result one cycle after the accepting edge.
- A table lookup raises its read request one cycle after acceptance.
- A table lookup presents its result one cycle after the response beat.

The bench drives each handshake at a falling edge and steps through rising edges one at a time. It samples at exactly the falling edge after the edge where each output is due, so a result that arrives a cycle early or late fails the check. Stall tests hold mem_rd_ready or res_ready low for several cycles and check that the request and the result stay stable throughout.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int ENTRY_W      = 64;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_GRAN_BIT = 2;
  localparam int CTL_CODE_LSB = 16;
  localparam int CODE_W       = 3;
  localparam int ENT_VLD_BIT  = 63;
  localparam int ENT_BIG_BIT  = 61;
  localparam int ENT_WR_BIT   = 1;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_DONE
  } state_e;
endpackage

// File: rtl/dxl_index_calc.sv
module dxl_index_calc #(
  parameter int ADDR_W       = 64,
  parameter int SMALL_SHIFT  = 13,
  parameter int LARGE_SHIFT  = 16,
  parameter int IDX_MIN_W    = 10,
  parameter int LARGE_MAX_CD = 5,
  parameter int ENTRY_LOG2   = 3
) (
  input  logic [ADDR_W-1:0]          vaddr,
  input  logic                       gran_large,
  input  logic [dxl_pkg::CODE_W-1:0] size_code,
  output logic [ADDR_W-1:0]          byte_off,
  output logic                       unsupported
);
  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] idx_mask;

  always_comb begin
    shifted     = gran_large ? (vaddr >> LARGE_SHIFT) : (vaddr >> SMALL_SHIFT);
    idx_mask    = (ADDR_W'(1) << (IDX_MIN_W + int'(size_code))) - ADDR_W'(1);
    byte_off    = (shifted & idx_mask) << ENTRY_LOG2;
    unsupported = gran_large && (int'(size_code) > LARGE_MAX_CD);
  end
endmodule

// File: rtl/dxl_entry_decode.sv
module dxl_entry_decode #(
  parameter int ADDR_W       = 64,
  parameter int PA_MSB       = 40,
  parameter int SMALL_SHIFT  = 13,
  parameter int LARGE_BASE_L = 15,
  parameter int LARGE_SHIFT  = 16
) (
  input  logic [dxl_pkg::ENTRY_W-1:0] entry,
  input  logic                        rsp_err,
  input  logic [ADDR_W-1:0]           vaddr,
  output dxl_pkg::perm_e              perm,
  output logic [ADDR_W-1:0]           page_base,
  output logic [ADDR_W-1:0]           off_mask,
  output logic [ADDR_W-1:0]           paddr
);
  import dxl_pkg::*;

  localparam logic [ENTRY_W-1:0] PA_TOP   = (ENTRY_W'(1) << (PA_MSB + 1)) - ENTRY_W'(1);
  localparam logic [ENTRY_W-1:0] SM_BASEM = PA_TOP & ~((ENTRY_W'(1) << SMALL_SHIFT) - ENTRY_W'(1));
  localparam logic [ENTRY_W-1:0] LG_BASEM = PA_TOP & ~((ENTRY_W'(1) << LARGE_BASE_L) - ENTRY_W'(1));
  localparam logic [ADDR_W-1:0]  SM_OFFM  = (ADDR_W'(1) << SMALL_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0]  LG_OFFM  = (ADDR_W'(1) << LARGE_SHIFT) - ADDR_W'(1);

  always_comb begin
    perm      = PERM_NONE;
    page_base = '0;
    off_mask  = '0;
    paddr     = '0;
    if (!rsp_err && entry[ENT_VLD_BIT]) begin
      perm = entry[ENT_WR_BIT] ? PERM_RW : PERM_RO;
      if (entry[ENT_BIG_BIT]) begin
        page_base = ADDR_W'(entry & LG_BASEM);
        off_mask  = LG_OFFM;
      end else begin
        page_base = ADDR_W'(entry & SM_BASEM);
        off_mask  = SM_OFFM;
      end
      paddr = page_base | (vaddr & off_mask);
    end
  end
endmodule

// File: rtl/dma_xlate_engine.sv
module dma_xlate_engine #(
  parameter int ADDR_W      = 64,
  parameter int CTRL_W      = 32,
  parameter int SMALL_SHIFT = 13,
  parameter int LARGE_SHIFT = 16,
  parameter int PA_MSB      = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [CTRL_W-1:0] req_ctrl,
  input  logic [ADDR_W-1:0] req_base,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [ADDR_W-1:0] res_page_base,
  output logic [ADDR_W-1:0] res_offset_mask,
  output logic [1:0]        res_perm
);
  import dxl_pkg::*;

  localparam logic [ADDR_W-1:0] BYP_MASK = (ADDR_W'(1) << SMALL_SHIFT) - ADDR_W'(1);

  state_e            state;
  logic [ADDR_W-1:0] lat_vaddr;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ADDR_W-1:0] off_w;
  logic              unsup_w;
  perm_e             dec_perm;
  logic [ADDR_W-1:0] dec_base, dec_mask, dec_paddr;
  logic [CODE_W-1:0] code_w;

  assign code_w = req_ctrl[CTL_CODE_LSB +: CODE_W];

  dxl_index_calc #(
    .ADDR_W(ADDR_W), .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
  ) u_idx (
    .vaddr(req_vaddr), .gran_large(req_ctrl[CTL_GRAN_BIT]), .size_code(code_w),
    .byte_off(off_w), .unsupported(unsup_w)
  );

  dxl_entry_decode #(
    .ADDR_W(ADDR_W), .PA_MSB(PA_MSB), .SMALL_SHIFT(SMALL_SHIFT),
    .LARGE_BASE_L(LARGE_SHIFT - 1), .LARGE_SHIFT(LARGE_SHIFT)
  ) u_dec (
    .entry(mem_rsp_data), .rsp_err(mem_rsp_err), .vaddr(lat_vaddr),
    .perm(dec_perm), .page_base(dec_base), .off_mask(dec_mask), .paddr(dec_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      lat_vaddr       <= '0;
      rd_addr_q       <= '0;
      res_paddr       <= '0;
      res_page_base   <= '0;
      res_offset_mask <= '0;
      res_perm        <= PERM_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          lat_vaddr <= req_vaddr;
          if (!req_ctrl[CTL_EN_BIT]) begin
            res_paddr       <= req_vaddr;
            res_page_base   <= req_vaddr & ~BYP_MASK;
            res_offset_mask <= BYP_MASK;
            res_perm        <= PERM_RW;
            state           <= ST_DONE;
          end else if (unsup_w) begin
            res_paddr       <= '0;
            res_page_base   <= '0;
            res_offset_mask <= '0;
            res_perm        <= PERM_NONE;
            state           <= ST_DONE;
          end else begin
            rd_addr_q <= req_base + off_w;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_rd_ready) state <= ST_DECODE;
        ST_DECODE: if (mem_rsp_valid) begin
          res_paddr       <= dec_paddr;
          res_page_base   <= dec_base;
          res_offset_mask <= dec_mask;
          res_perm        <= dec_perm;
          state           <= ST_DONE;
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_FETCH);
  assign mem_rd_addr  = rd_addr_q;
  assign res_valid    = (state == ST_DONE);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) &&
      $stable(res_perm) && $stable(res_offset_mask) && $stable(res_page_base));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid || res_valid) |-> !req_ready);

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_ctrl[CTL_EN_BIT] |=>
      res_valid && res_perm == PERM_RW && res_paddr == $past(req_vaddr));

  // R4
  unsup_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_ctrl[CTL_EN_BIT] && req_ctrl[CTL_GRAN_BIT] &&
      (req_ctrl[CTL_CODE_LSB +: CODE_W] > 3'd5) |=> res_valid && res_perm == PERM_NONE);

  // R9
  err_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && mem_rsp_err && !req_ready && !mem_rd_valid && !res_valid |=>
      res_valid && res_perm == PERM_NONE);
endmodule

// File: tb/tb_dma_xlate_engine.sv
module tb_dma_xlate_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [63:0] vaddr;
    logic [31:0] ctrl;
    logic [63:0] base;
    logic [63:0] entry;
    logic        err;
    logic        rd;
    logic [63:0] rdaddr;
    logic [63:0] paddr;
    logic [63:0] pbase;
    logic [63:0] mask;
    logic [1:0]  perm;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R1 bypass
    '{64'h0000_0001_2345_6789, 32'h0, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0,
      64'h0000_0001_2345_6789, 64'h0000_0001_2345_6000, 64'h1FFF, 2'b11},
    // R2 R8 R6 8K n=0 writable small page
    '{64'h0000_0000_0012_A456, 32'h1, 64'h1000_0000, 64'h8000_0123_4567_E002, 1'b0, 1'b1,
      64'h1000_04A8, 64'h0000_0123_4567_E456, 64'h0000_0123_4567_E000, 64'h1FFF, 2'b11},
    // R2 index truncation, R8 bit 12 dropped, R6 read-only
    '{64'h0000_0000_00F0_2008, 32'h1, 64'h2000_0000, 64'h8000_0000_0ABC_D000, 1'b0, 1'b1,
      64'h2000_1C08, 64'h0ABC_C008, 64'h0ABC_C000, 64'h1FFF, 2'b01},
    // R2 n=7, R7 64K entry in 8K table
    '{64'h0000_0000_7FFF_E000, 32'h0007_0001, 64'h0, 64'hA000_01AB_CDEF_8002, 1'b0, 1'b1,
      64'h000F_FFF8, 64'h0000_01AB_CDEF_E000, 64'h0000_01AB_CDEF_8000, 64'hFFFF, 2'b11},
    // R3 n=0, R7 read-only
    '{64'h0000_0000_0345_6789, 32'h5, 64'h0000_0004_0000_0000, 64'hA000_0000_5555_0000, 1'b0, 1'b1,
      64'h0000_0004_0000_1A28, 64'h5555_6789, 64'h5555_0000, 64'hFFFF, 2'b01},
    // R3 n=5, R5 invalid entry
    '{64'hFFFF_FFFF_FFFF_0000, 32'h0005_0005, 64'h8, 64'h2000_0000_1234_0002, 1'b0, 1'b1,
      64'h0004_0000, 64'h0, 64'h0, 64'h0, 2'b00},
    // R4 code 6
    '{64'h0000_0000_0345_6789, 32'h0006_0005, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0,
      64'h0, 64'h0, 64'h0, 2'b00},
    // R4 code 7
    '{64'h0000_0000_0345_6789, 32'h0007_0005, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0,
      64'h0, 64'h0, 64'h0, 2'b00},
    // R9 read error, R2 n=3
    '{64'h0000_0000_0400_2000, 32'h0003_0001, 64'h100, 64'h8000_0000_0000_2002, 1'b1, 1'b1,
      64'h108, 64'h0, 64'h0, 64'h0, 2'b00},
    // R2 n=3 top index bit 25
    '{64'h0000_0000_0200_0000, 32'h0003_0001, 64'h0, 64'h8000_0000_0000_0002, 1'b0, 1'b1,
      64'h8000, 64'h0, 64'h0, 64'h1FFF, 2'b11},
    // R1 enable clear wins over unsupported code
    '{64'hDEAD_BEEF_0000_1FFF, 32'h0007_0004, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0,
      64'hDEAD_BEEF_0000_1FFF, 64'hDEAD_BEEF_0000_0000, 64'h1FFF, 2'b11}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [31:0] req_ctrl = '0;
  logic [63:0] req_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_paddr, res_page_base, res_offset_mask;
  logic [1:0]  res_perm;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd_valid) rd_cycles <= rd_cycles + 1;

  dma_xlate_engine dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_ctrl(req_ctrl), .req_base(req_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_page_base(res_page_base), .res_offset_mask(res_offset_mask), .res_perm(res_perm)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xlate(input vec_t v, input int rd_stall, input int res_stall);
    int rd0;
    string rtag;
    rtag = v.ctrl[2] ? "R3" : "R2";
    @(negedge clk);
    chk("R11 idle before request", {63'b0, req_ready}, 64'd1);
    req_valid = 1'b1; req_vaddr = v.vaddr; req_ctrl = v.ctrl; req_base = v.base;
    rd0 = rd_cycles;
    step();
    req_valid = 1'b0;
    if (v.rd) begin
      chk("R10 read due one cycle after accept", {63'b0, mem_rd_valid}, 64'd1);
      chk(rtag, mem_rd_addr, v.rdaddr);
      chk("R10 busy", {63'b0, req_ready}, 64'd0);
      for (int i = 0; i < rd_stall; i++) begin
        step();
        chk("R10 read held", {63'b0, mem_rd_valid}, 64'd1);
        chk("R10 addr stable", mem_rd_addr, v.rdaddr);
      end
      mem_rd_ready = 1'b1;
      step();
      mem_rd_ready = 1'b0;
      chk("R10 single read", {63'b0, mem_rd_valid}, 64'd0);
      mem_rsp_valid = 1'b1; mem_rsp_data = v.entry; mem_rsp_err = v.err;
      step();
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    end else begin
      chk("R1 R4 no read issued", 64'(rd_cycles - rd0 + (mem_rd_valid ? 1 : 0)), 64'd0);
    end
    chk("R11 result due", {63'b0, res_valid}, 64'd1);
    chk("R5 R6 R9 perm", {62'b0, res_perm}, {62'b0, v.perm});
    chk("R7 R8 paddr", res_paddr, v.paddr);
    chk("R7 R8 page base", res_page_base, v.pbase);
    chk("R7 R8 offset mask", res_offset_mask, v.mask);
    for (int i = 0; i < res_stall; i++) begin
      step();
      chk("R11 result held", {63'b0, res_valid}, 64'd1);
      chk("R11 paddr stable", res_paddr, v.paddr);
    end
    res_ready = 1'b1;
    step();
    res_ready = 1'b0;
    chk("R11 released", {62'b0, res_valid, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12
    chk("R12 req_ready", {63'b0, req_ready}, 64'd1);
    chk("R12 mem_rd_valid", {63'b0, mem_rd_valid}, 64'd0);
    chk("R12 res_valid", {63'b0, res_valid}, 64'd0);
    for (int k = 0; k < NV; k++) xlate(VECS[k], 0, 0);
    // R10 R11 stalled handshakes
    xlate(VECS[1], 3, 2);
    xlate(VECS[4], 1, 3);
    xlate(VECS[6], 0, 2);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule